// File: doc/BRIEF.md
# Skip-Code Synchronous Toggle Counter

This block is a 3-bit synchronous counter. On every enabled clock edge it moves through a fixed cycle of six codes: 0, 1, 3, 4, 5, 7, and then back to 0. Codes 2 and 6 are not part of the cycle. The count is not built from an adder. Each bit is a toggle cell, and its toggle input comes from a small minimized equation of the present state.

All three cells share one clock. The same equations also carry the two unused codes back into the cycle, so the counter starts by itself from any power-up value.

The states are named in the package type `seq_code_e`:

| Name | Code | Role |
|------|------|------|
| CODE_ZERO | 0 | main cycle |
| CODE_ONE | 1 | main cycle |
| CODE_THREE | 3 | main cycle |
| CODE_FOUR | 4 | main cycle |
| CODE_FIVE | 5 | main cycle |
| CODE_SEVEN | 7 | main cycle |
| CODE_SKIP2 | 2 | unused |
| CODE_SKIP6 | 6 | unused |

The transitions are:
- ZERO→ONE, ONE→THREE, THREE→FOUR, FOUR→FIVE, FIVE→SEVEN, SEVEN→ZERO (the wrap).
- SKIP2→SEVEN and SKIP6→THREE (recovery).
- Any state→itself while the enable is low.

A one-cycle flag marks the enabled cycle in which the count leaves SEVEN.

Top module: `skip_seq_counter`

## Requirements
- R1: With `en`=1 and `rst`=0, each rising clock edge moves `count` along 0→1→3→4→5→7→0.
- R2: With `en`=0 and `rst`=0, `count` keeps its value across the clock edge.
- R3: A rising edge with `rst`=1 loads `count` with parameter RESET_CODE (default 0), whatever the value of `en`.
- R4: From the unused code 2 (binary 010), an enabled edge gives 7.
- R5: From the unused code 6 (binary 110), an enabled edge gives 3.
- R6: `wrap` is 1 exactly while `count`=7 and `en`=1, and 0 otherwise. It is combinational from the present count and `en`.
- R7: With `en`=0, all three toggle inputs are 0.
- R8: With `en`=1, the toggle inputs follow three equations:
  - bit 2 toggles when bit 1 is 1;
  - bit 1 toggles when bit 0 is 1;
  - bit 0 toggles when bit 1 is 1 or bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all state bits |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| count | output | 3 | Present counter code |
| wrap | output | 1 | Marks the enabled cycle at code 7 |

## Verification
The bench builds three copies of the block. One uses the default RESET_CODE of 0. The other two use RESET_CODE values of 2 and 6, so reset places them directly in an unused code that the ports could not otherwise reach. This lets the first enabled edge after reset show the SKIP2→SEVEN and SKIP6→THREE recoveries. The default copy runs the main cycle several times under mixed enable patterns and under a reset taken mid-cycle with the enable high.

// File: rtl/seq_ctr_pkg.sv
`timescale 1ns/1ps
package seq_ctr_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_ZERO  = 3'd0,
        CODE_ONE   = 3'd1,
        CODE_SKIP2 = 3'd2,
        CODE_THREE = 3'd3,
        CODE_FOUR  = 3'd4,
        CODE_FIVE  = 3'd5,
        CODE_SKIP6 = 3'd6,
        CODE_SEVEN = 3'd7
    } seq_code_e;

    // Successor as a table; used only by checks, not by the datapath.
    function automatic logic [CODE_W-1:0] seq_next(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] n;
        unique case (c)
            3'd0:    n = 3'd1;
            3'd1:    n = 3'd3;
            3'd2:    n = 3'd7;
            3'd3:    n = 3'd4;
            3'd4:    n = 3'd5;
            3'd5:    n = 3'd7;
            3'd6:    n = 3'd3;
            default: n = 3'd0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/seq_ctr_toggle_logic.sv
`timescale 1ns/1ps
module seq_ctr_toggle_logic
    import seq_ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] q,
    output logic [CODE_W-1:0] t
);
    logic [CODE_W-1:0] t_raw;

    // Minimized toggle equations of the present state (R8).
    always_comb begin
        t_raw[2] = q[1];
        t_raw[1] = q[0];
        t_raw[0] = q[1] | ~q[0];
    end

    assign t = en ? t_raw : '0;

    // R7: a disabled cycle presents no toggle request.
    a_r7_no_toggle_idle: assert property (@(posedge clk) disable iff (rst)
        !en |-> (t == '0));

    // R8: at most the low bit toggles when the middle and low bits are both 0.
    a_r8_low_start: assert property (@(posedge clk) disable iff (rst)
        (en && q[1:0] == 2'b00) |-> (t == 3'b001));
endmodule

// File: rtl/seq_ctr_tff_bank.sv
`timescale 1ns/1ps
module seq_ctr_tff_bank
    import seq_ctr_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] t,
    output logic [CODE_W-1:0] q
);
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic q_r;
        always_ff @(posedge clk) begin
            if (rst)       q_r <= RESET_CODE[b];
            else if (t[b]) q_r <= ~q_r;
        end
        assign q[b] = q_r;
    end

    // A cleared toggle input leaves the bank unchanged.
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (t == '0) |=> $stable(q));
endmodule

// File: rtl/skip_seq_counter.sv
`timescale 1ns/1ps
module skip_seq_counter
    import seq_ctr_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [2:0] count,
    output logic       wrap
);
    logic [CODE_W-1:0] toggles;
    logic [CODE_W-1:0] state_q;
    seq_code_e         state;

    seq_ctr_toggle_logic u_tlogic (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .q   (state_q),
        .t   (toggles)
    );

    seq_ctr_tff_bank #(.RESET_CODE(RESET_CODE)) u_bank (
        .clk (clk),
        .rst (rst),
        .t   (toggles),
        .q   (state_q)
    );

    assign state = seq_code_e'(state_q);
    assign count = state_q;

    // Output process: the wrap flag is decoded from the named state.
    always_comb begin
        unique case (state)
            CODE_SEVEN: wrap = en;
            CODE_ZERO, CODE_ONE, CODE_THREE, CODE_FOUR, CODE_FIVE,
            CODE_SKIP2, CODE_SKIP6: wrap = 1'b0;
            default: wrap = 1'b0;
        endcase
    end

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        en |=> (count == seq_next($past(count))));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    a_r3_reset_load: assert property (@(posedge clk)
        rst |=> (count == RESET_CODE));

    a_r4_skip2_recover: assert property (@(posedge clk) disable iff (rst)
        (en && count == 3'd2) |=> (count == 3'd7));

    a_r5_skip6_recover: assert property (@(posedge clk) disable iff (rst)
        (en && count == 3'd6) |=> (count == 3'd3));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == 3'd0));
endmodule

// File: tb/skip_seq_counter_tb.sv
`timescale 1ns/1ps
module skip_seq_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;

    logic [2:0] cnt0, cnt2, cnt6;
    logic       wrap0, wrap2, wrap6;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        int         which;
        logic [2:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];

    logic [2:0] m0, m2, m6;

    always #5 clk = ~clk;

    skip_seq_counter #(.RESET_CODE(3'd0)) u_dut (
        .clk(clk), .rst(rst), .en(en), .count(cnt0), .wrap(wrap0));
    skip_seq_counter #(.RESET_CODE(3'd2)) u_dut_c2 (
        .clk(clk), .rst(rst), .en(en), .count(cnt2), .wrap(wrap2));
    skip_seq_counter #(.RESET_CODE(3'd6)) u_dut_c6 (
        .clk(clk), .rst(rst), .en(en), .count(cnt6), .wrap(wrap6));

    function automatic logic [2:0] ref_next(input logic [2:0] c);
        case (c)
            3'd0: return 3'd1;
            3'd1: return 3'd3;
            3'd3: return 3'd4;
            3'd4: return 3'd5;
            3'd5: return 3'd7;
            3'd7: return 3'd0;
            3'd2: return 3'd7;
            default: return 3'd3;
        endcase
    endfunction

    function automatic string req_for(input logic [2:0] c, input logic r, input logic e);
        if (r) return "R3";
        if (!e) return "R2";
        if (c == 3'd2) return "R4";
        if (c == 3'd6) return "R5";
        return "R1";
    endfunction

    function automatic logic [2:0] model(input logic [2:0] c, input logic r,
                                         input logic e, input logic [2:0] rc);
        if (r) return rc;
        if (!e) return c;
        return ref_next(c);
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: sets inputs away from the edge, checks wrap, queues expectations.
    task automatic apply(input logic r, input logic e);
        item_t it;
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        check("R6 wrap", {2'b00, wrap0}, {2'b00, (m0 == 3'd7) && e});
        it.which = 0; it.exp = model(m0, r, e, 3'd0); it.req = req_for(m0, r, e);
        sb_q.push_back(it);
        it.which = 2; it.exp = model(m2, r, e, 3'd2); it.req = req_for(m2, r, e);
        sb_q.push_back(it);
        it.which = 6; it.exp = model(m6, r, e, 3'd6); it.req = req_for(m6, r, e);
        sb_q.push_back(it);
        m0 = model(m0, r, e, 3'd0);
        m2 = model(m2, r, e, 3'd2);
        m6 = model(m6, r, e, 3'd6);
    endtask

    // Monitor: pops every expectation queued before this edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                case (it.which)
                    0:       check(it.req, cnt0, it.exp);
                    2:       check({it.req, " c2"}, cnt2, it.exp);
                    default: check({it.req, " c6"}, cnt6, it.exp);
                endcase
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m0 = 3'd0; m2 = 3'd2; m6 = 3'd6;
        // R3: reset with enable low, then with enable high.
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b1);
        // R4, R5: the first enabled edge recovers the unused codes; R1 cycle.
        for (int i = 0; i < 14; i++) apply(1'b0, 1'b1);
        // R2: hold at several codes.
        for (int i = 0; i < 8; i++) begin
            apply(1'b0, 1'b0);
            apply(1'b0, 1'b1);
        end
        // R6: idle while sitting at code 7, then enabled.
        while (m0 != 3'd7) apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        // Mixed enable pattern.
        for (int i = 0; i < 40; i++) apply(1'b0, 1'($urandom_range(1)));
        // R3: mid-cycle reset with enable high, then recovery again.
        apply(1'b0, 1'b1);
        apply(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) apply(1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule